// File: doc/BRIEF.md
# Parity-Protected Register Bank

This block holds a small array of software-visible words and guards each of them with parity. Check bits are computed from the word contents on every write and stored beside the data. On every read the check bits are computed again and compared with the stored ones. Parity can only detect a fault, not repair it. A mismatch therefore marks the read as faulty and raises a sticky error flag, and the surrounding system decides how to react.

A build-time parameter chooses the grouping: one check bit for each byte, or one check bit for the whole word. A second parameter chooses even or odd polarity. An injection input inverts the check bits that a write stores, while the data bits are stored unchanged. This lets the live checker be exercised on demand, both in a testbench and in a running system. The error flag records the address of the first faulty read and stays set until a dedicated clear input is pulsed.

Top module: `parity_reg_bank`

## Requirements
- R1: After reset every word reads as zero with `rd_err` low, and `err_flag`, `err_addr` and `rvalid` are zero. Reset check bits match zero data, so no read flags an error until something corrupts a word.
- R2: A read request (`rd_en` high at a rising edge) returns the word at `addr` on `rdata`, with `rvalid` high, after that same edge. `rvalid` is low after any edge without a request. A read and a write to the same address in one cycle return the old contents.
- R3: A write updates only the bytes whose `wbe` bit is set. Byte i is `wdata[8i+7:8i]` and is enabled by `wbe[i]`. A write with all enables low changes nothing.
- R4: A word last written with `inj_err` low in every group that was written reads back with `rd_err` low.
- R5: A write with `inj_err` high stores the data unchanged but with inverted check bits for every group it writes. A later read of that word returns the written data with `rd_err` high.
- R6: In per-byte mode (`PER_BYTE`=1), a partial write regenerates only the check bits of the enabled bytes, so an injected fault in a byte that is not enabled persists. In per-word mode, any write with at least one enable regenerates the single check bit from the merged word.
- R7: `err_flag` goes high at the edge that completes a faulty read and stays high until an edge with `err_clr` high and no faulty read.
- R8: `err_addr` captures the address of the faulty read that sets `err_flag`. It does not change while the flag stays set.
- R9: A faulty read and `err_clr` in the same cycle leave `err_flag` high, and `err_addr` takes the address of that new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Word address shared by reads and writes |
| wdata | input | DATA_W | Write data |
| wbe | input | DATA_W/8 | Byte enables for writes |
| inj_err | input | 1 | Invert the check bits stored by this write |
| err_clr | input | 1 | Clear the sticky error flag |
| rdata | output | DATA_W | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| rd_err | output | 1 | Parity mismatch on the returned read |
| err_flag | output | 1 | Sticky parity error flag |
| err_addr | output | ADDR_W | Address of the first faulty read |

## Verification
The bench runs a per-byte instance and a per-word instance side by side, so the R6 cases show up as diverging `rd_err` values. One case injects a fault across a word, then rewrites only one byte. A design that regenerated every check bit on a partial write would hide the fault in the per-byte instance. A design that kept stale bits would keep flagging it in the per-word instance. Other cases clear the flag in the same cycle as a new faulty read, raise a second fault while the flag is already set, and write with all enables low. These catch a clear that beats a set, an address that is overwritten by later faults, and an empty write that still touches check bits. Reading every word right after reset catches check bits that reset to the wrong polarity.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
   localparam int unsigned BYTE_W = 8;

   // number of parity groups for a word of dw bits
   function automatic int unsigned group_count(input int unsigned dw, input bit per_byte);
      return per_byte ? dw / BYTE_W : 1;
   endfunction
endpackage

// File: rtl/pbank_pgen.sv
module pbank_pgen #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned GRP_W  = 8,
   parameter bit          ODD    = 1'b0
) (
   input  logic [DATA_W-1:0]       data,
   output logic [DATA_W/GRP_W-1:0] par
);
   localparam int unsigned NG = DATA_W / GRP_W;

   if (DATA_W % GRP_W != 0) begin : g_bad_grp
      $error("pbank_pgen: DATA_W must be a multiple of GRP_W");
   end

   for (genvar g = 0; g < NG; g++) begin : g_grp
      assign par[g] = (^data[g*GRP_W +: GRP_W]) ^ ODD;
   end
endmodule

// File: rtl/pbank_pchk.sv
module pbank_pchk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned GRP_W  = 8,
   parameter bit          ODD    = 1'b0
) (
   input  logic [DATA_W-1:0]       data,
   input  logic [DATA_W/GRP_W-1:0] stored,
   output logic                    mismatch
);
   localparam int unsigned NG = DATA_W / GRP_W;
   logic [NG-1:0] fresh;

   pbank_pgen #(.DATA_W(DATA_W), .GRP_W(GRP_W), .ODD(ODD)) u_gen (
      .data (data),
      .par  (fresh)
   );

   assign mismatch = |(fresh ^ stored);
endmodule

// File: rtl/pbank_errlog.sv
module pbank_errlog #(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic              clr,
   output logic              err,
   output logic [ADDR_W-1:0] err_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err      <= 1'b0;
         err_addr <= '0;
      end else if (set) begin
         err <= 1'b1;
         if (!err || clr) err_addr <= set_addr;
      end else if (clr) begin
         err <= 1'b0;
      end
   end

   p_set_r7: assert property (@(posedge clk) disable iff (!rst_n) set |=> err)
      else $error("R7: error flag did not set");
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n) clr && !set |=> !err)
      else $error("R7: error flag did not clear");
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) err && !clr |=> err)
      else $error("R7: error flag dropped without clear");
   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n) err && !clr |=> $stable(err_addr))
      else $error("R8: error address moved while flag held");
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n) set && clr |=> err && (err_addr == $past(set_addr)))
      else $error("R9: clear beat a new fault");
endmodule

// File: rtl/parity_reg_bank.sv
module parity_reg_bank #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_REGS = 8,
   parameter bit          PER_BYTE = 1'b1,
   parameter bit          ODD      = 1'b0,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   input  logic [DATA_W/pbank_pkg::BYTE_W-1:0] wbe,
   input  logic                          inj_err,
   input  logic                          err_clr,
   output logic [DATA_W-1:0]             rdata,
   output logic                          rvalid,
   output logic                          rd_err,
   output logic                          err_flag,
   output logic [ADDR_W-1:0]             err_addr
);
   import pbank_pkg::*;

   localparam int unsigned BE_W  = DATA_W / BYTE_W;
   localparam int unsigned NG    = group_count(DATA_W, PER_BYTE);
   localparam int unsigned GRP_W = DATA_W / NG;
   localparam logic [NG-1:0] RST_PAR = ODD ? '1 : '0;

   if (DATA_W % BYTE_W != 0 || DATA_W == 0) begin : g_bad_width
      $error("parity_reg_bank: DATA_W must be a non-zero multiple of 8");
   end
   if (NUM_REGS < 2 || (1 << ADDR_W) != NUM_REGS) begin : g_bad_depth
      $error("parity_reg_bank: NUM_REGS must be a power of two, at least 2");
   end

   logic [DATA_W-1:0] mem_d [NUM_REGS];
   logic [NG-1:0]     mem_p [NUM_REGS];

   // ---------------- write path ----------------
   logic [DATA_W-1:0] cur_d, merged;
   logic [NG-1:0]     cur_p, gen_w, new_p;
   logic              wr_go;

   assign cur_d = mem_d[addr];
   assign cur_p = mem_p[addr];
   assign wr_go = wr_en && (|wbe);

   for (genvar b = 0; b < BE_W; b++) begin : g_merge
      assign merged[b*BYTE_W +: BYTE_W] = wbe[b] ? wdata[b*BYTE_W +: BYTE_W]
                                                 : cur_d[b*BYTE_W +: BYTE_W];
   end

   pbank_pgen #(.DATA_W(DATA_W), .GRP_W(GRP_W), .ODD(ODD)) u_wgen (
      .data (merged),
      .par  (gen_w)
   );

   if (PER_BYTE) begin : g_byte_par
      for (genvar g = 0; g < NG; g++) begin : g_sel
         assign new_p[g] = wbe[g] ? (gen_w[g] ^ inj_err) : cur_p[g];
      end
   end else begin : g_word_par
      assign new_p = gen_w ^ {NG{inj_err}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            mem_d[i] <= '0;
            mem_p[i] <= RST_PAR;
         end
      end else if (wr_go) begin
         mem_d[addr] <= merged;
         mem_p[addr] <= new_p;
      end
   end

   // ---------------- read path ----------------
   logic rd_mism;

   pbank_pchk #(.DATA_W(DATA_W), .GRP_W(GRP_W), .ODD(ODD)) u_rchk (
      .data     (cur_d),
      .stored   (cur_p),
      .mismatch (rd_mism)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
         rd_err <= 1'b0;
      end else begin
         rvalid <= rd_en;
         rd_err <= rd_en && rd_mism;
         if (rd_en) rdata <= cur_d;
      end
   end

   pbank_errlog #(.ADDR_W(ADDR_W)) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (rd_en && rd_mism),
      .set_addr (addr),
      .clr      (err_clr),
      .err      (err_flag),
      .err_addr (err_addr)
   );

   p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rvalid)
      else $error("R2: missing read valid");
   p_no_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rvalid)
      else $error("R2: spurious read valid");
   p_rerr_valid_r5: assert property (@(posedge clk) disable iff (!rst_n) rd_err |-> rvalid && err_flag)
      else $error("R5: read error outside a read or without sticky flag");
   p_empty_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && (wbe == '0) && rd_en |=> rdata == $past(cur_d))
      else $error("R3: empty write disturbed read data");
endmodule

// File: tb/parity_reg_bank_tb.sv
module parity_reg_bank_tb;
   localparam int DW = 32;
   localparam int NR = 8;
   localparam int AW = 3;
   localparam int BW = DW / 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0, rd_en = 0, inj_err = 0, err_clr = 0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [BW-1:0] wbe = '0;

   logic [DW-1:0] rdata_b, rdata_w;
   logic rvalid_b, rvalid_w, rd_err_b, rd_err_w, err_b, err_w;
   logic [AW-1:0] ea_b, ea_w;

   always #4 clk = ~clk;

   parity_reg_bank #(.DATA_W(DW), .NUM_REGS(NR), .PER_BYTE(1'b1), .ODD(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .wbe(wbe), .inj_err(inj_err), .err_clr(err_clr),
      .rdata(rdata_b), .rvalid(rvalid_b), .rd_err(rd_err_b),
      .err_flag(err_b), .err_addr(ea_b));

   parity_reg_bank #(.DATA_W(DW), .NUM_REGS(NR), .PER_BYTE(1'b0), .ODD(1'b1)) u_dut_word (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .wbe(wbe), .inj_err(inj_err), .err_clr(err_clr),
      .rdata(rdata_w), .rvalid(rvalid_w), .rd_err(rd_err_w),
      .err_flag(err_w), .err_addr(ea_w));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [DW-1:0] md [NR];
   logic [BW-1:0] bad_b [NR];
   logic          bad_w [NR];
   logic m_eb = 0, m_ew = 0;
   logic [AW-1:0] m_ab = '0, m_aw = '0;

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [BW-1:0] be);
      logic [DW-1:0] r = old;
      for (int b = 0; b < BW; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
      return r;
   endfunction

   task automatic log_upd(inout logic e, inout logic [AW-1:0] ea, input bit set, input logic [AW-1:0] a, input bit clr);
      if (set) begin
         if (!e || clr) ea = a;
         e = 1'b1;
      end else if (clr) e = 1'b0;
   endtask

   task automatic cyc(input bit wr, input bit rd, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [BW-1:0] be, input bit inj, input bit clr);
      logic [DW-1:0] ed;
      logic eeb, eew;
      @(negedge clk);
      wr_en = wr; rd_en = rd; addr = a; wdata = wd; wbe = be; inj_err = inj; err_clr = clr;
      @(posedge clk);
      ed  = md[a];
      eeb = |bad_b[a];
      eew = bad_w[a];
      log_upd(m_eb, m_ab, rd && eeb, a, clr);
      log_upd(m_ew, m_aw, rd && eew, a, clr);
      if (wr && be != '0) begin
         md[a] = merge(md[a], wd, be);
         for (int b = 0; b < BW; b++) if (be[b]) bad_b[a][b] = inj;
         bad_w[a] = inj;
      end
      #2;
      chk(rvalid_b == rd && rvalid_w == rd, "R2 rvalid", {rvalid_b, rvalid_w}, {rd, rd});
      if (rd) begin
         chk(rdata_b == ed, "R2/R3 rdata byte-mode", rdata_b, ed);
         chk(rdata_w == ed, "R2/R3 rdata word-mode", rdata_w, ed);
         chk(rd_err_b == eeb, eeb ? "R5/R6 rd_err byte-mode" : "R4/R6 rd_err byte-mode", rd_err_b, eeb);
         chk(rd_err_w == eew, eew ? "R5/R6 rd_err word-mode" : "R4/R6 rd_err word-mode", rd_err_w, eew);
      end
      chk(err_b == m_eb && err_w == m_ew, "R7 err_flag", {err_b, err_w}, {m_eb, m_ew});
      if (m_eb) chk(ea_b == m_ab, "R8 err_addr byte-mode", ea_b, m_ab);
      if (m_ew) chk(ea_w == m_aw, "R8 err_addr word-mode", ea_w, m_aw);
   endtask

   initial begin
      for (int i = 0; i < 200000; i++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5a5a));
      for (int i = 0; i < NR; i++) begin md[i] = '0; bad_b[i] = '0; bad_w[i] = 0; end
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk(rvalid_b == 0 && rvalid_w == 0 && err_b == 0 && err_w == 0, "R1 outputs after reset",
          {rvalid_b, rvalid_w, err_b, err_w}, 0);
      chk(ea_b == 0 && ea_w == 0 && rdata_b == 0, "R1 err_addr/rdata after reset", {ea_b, ea_w}, 0);
      @(negedge clk); rst_n = 1'b1;
      // R1: every word reads zero with no parity error
      for (int i = 0; i < NR; i++) cyc(0, 1, AW'(i), '0, '0, 0, 0);
      // R2 full write and read back
      cyc(1, 0, 3, 32'hA5C3_0F69, 4'hF, 0, 0);
      cyc(0, 1, 3, '0, '0, 0, 0);
      // R3 partial write
      cyc(1, 0, 3, 32'h1122_3344, 4'b0010, 0, 0);
      cyc(0, 1, 3, '0, '0, 0, 0);
      chk(rdata_b == 32'hA5C3_3369, "R3 partial write byte 1 only", rdata_b, 32'hA5C3_3369);
      // R3 empty write, read/write same address returns old
      cyc(1, 1, 3, 32'hFFFF_FFFF, 4'h0, 1, 0);
      cyc(1, 1, 4, 32'h0BAD_F00D, 4'hF, 0, 0);
      cyc(0, 1, 4, '0, '0, 0, 0);
      // R5 injection
      cyc(1, 0, 2, 32'hDEAD_BEEF, 4'hF, 1, 0);
      cyc(0, 1, 2, '0, '0, 0, 0);
      chk(rd_err_b && rd_err_w && rdata_b == 32'hDEAD_BEEF, "R5 injected read", {rd_err_b, rd_err_w}, 2'b11);
      // R8 second fault keeps first address
      cyc(1, 0, 5, 32'h0000_0001, 4'h1, 1, 0);
      cyc(0, 1, 5, '0, '0, 0, 0);
      chk(ea_b == 2 && ea_w == 2, "R8 first address kept", {ea_b, ea_w}, {3'd2, 3'd2});
      // R6 partial clean rewrite of injected word
      cyc(1, 0, 2, 32'h0000_5500, 4'b0010, 0, 0);
      cyc(0, 1, 2, '0, '0, 0, 0);
      chk(rd_err_b == 1 && rd_err_w == 0, "R6 per-byte keeps, per-word regenerates", {rd_err_b, rd_err_w}, 2'b10);
      cyc(1, 0, 2, 32'h0000_0000, 4'hF, 0, 0);
      cyc(0, 1, 2, '0, '0, 0, 0);
      // R7 clear
      cyc(0, 0, 0, '0, '0, 0, 1);
      chk(err_b == 0 && err_w == 0, "R7 cleared", {err_b, err_w}, 0);
      // R9 set beats clear, new address taken
      cyc(0, 1, 5, '0, '0, 0, 0);
      cyc(0, 1, 5, '0, '0, 0, 1);
      chk(err_b && ea_b == 5, "R9 set wins over clear", {err_b, ea_b}, {1'b1, 3'd5});
      cyc(0, 0, 0, '0, '0, 0, 1);
      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [2:0] op = 3'($urandom_range(0, 7));
         cyc(op[0] | op[2], op[1], AW'($urandom_range(0, NR-1)), $urandom,
             BW'($urandom_range(0, 15)), ($urandom_range(0, 15) == 0), ($urandom_range(0, 31) == 0));
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule